// File: doc/BRIEF.md
# Multiway-Branch Moore Microsequencer

This block is a microprogrammed control unit. It holds a fixed microcode store of 64-bit words and a microaddress register. In every cycle the word at the current microaddress drives two control outputs: a one-hot register clock enable and a source-select code for the datapath multiplexer. The same word also names a condition selection and four complete successor addresses. At the clock edge, two external condition flags chosen by the selection form a 2-bit index. That index picks one of the four successors, and the picked address becomes the next microaddress. No microprogram counter is incremented.

The control outputs are a pure function of the registered microaddress, which makes this a Moore machine. The condition flags only affect which word is loaded at the next edge, so they never reach the outputs within a cycle. All pins are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `mw_seq`

## Requirements
- R1: Each microword is 64 bits wide. From the most significant end it holds, in this order: a 4-bit register select, a 4-bit source code, a 4-bit condition select, and four 13-bit successor addresses, numbered 0 to 3.
- R2: The store holds 256 words and is indexed by microaddress bits [7:0]. The word at address a has register select ((a mod 16) xor (a div 16)), source code (a div 16), condition select ((3a) mod 16), and successor k equal to ((13a + 61k + 7) mod 256).
- R3: `reg_en` has at most one bit set. A register select of 0 sets no bit. A register select of k, with k from 1 to 15, sets only bit k-1.
- R4: `src_sel` equals the source code of the current word.
- R5: When condition-select bit 3 is 0, let L be bits [2:0] of the condition select. The index is {cond[(L+1) mod 8], cond[L]}.
- R6: When condition-select bit 3 is 1, the index is {0, cond[L]}. Only successors 0 and 1 can then be reached, and the neighbouring flag has no effect.
- R7: Index 00 selects successor 0, 01 selects successor 1, 10 selects successor 2 and 11 selects successor 3.
- R8: A synchronous reset loads microaddress 0. After that edge the outputs show word 0: `reg_en` = 0 and `src_sel` = 0.
- R9: Changing `cond` between clock edges leaves `reg_en` and `src_sel` unchanged.
- R10: `cond` is sampled at the rising edge. The outputs of the selected successor appear in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 8 | External condition flags |
| reg_en | output | 15 | One-hot register clock enables |
| src_sel | output | 4 | Datapath source-select code |

## Verification
Every output is read directly from the word at the registered microaddress. A wrong microaddress therefore shows on `reg_en` and `src_sel` in the very next cycle, as the fields of some other word. A wrong condition choice is visible the same way: it sends the sequence down a different successor, and the outputs differ from the expected word one cycle after the edge that sampled the flags. The path then keeps diverging from the model's path on later steps. A leak from `cond` into the outputs shows as a change on the outputs between edges.

// File: rtl/mw_seq_pkg.sv
package mw_seq_pkg;
  localparam int SEL_W   = 4;
  localparam int MUX_W   = 4;
  localparam int CND_W   = 4;
  localparam int NA_W    = 13;
  localparam int REG_N   = (1 << SEL_W) - 1;
  localparam int STORE_N = 256;

  typedef struct packed {
    logic [SEL_W-1:0] rsel;
    logic [MUX_W-1:0] src;
    logic [CND_W-1:0] csel;
    logic [NA_W-1:0]  nxt0;
    logic [NA_W-1:0]  nxt1;
    logic [NA_W-1:0]  nxt2;
    logic [NA_W-1:0]  nxt3;
  } uword_t;

  // Microprogram content, computed per address
  function automatic uword_t fill_word(input int unsigned a);
    uword_t w;
    w.rsel = SEL_W'((a % 16) ^ ((a / 16) % 16));
    w.src  = MUX_W'((a / 16) % 16);
    w.csel = CND_W'((3 * a) % 16);
    w.nxt0 = NA_W'((13 * a + 7) % STORE_N);
    w.nxt1 = NA_W'((13 * a + 61 + 7) % STORE_N);
    w.nxt2 = NA_W'((13 * a + 122 + 7) % STORE_N);
    w.nxt3 = NA_W'((13 * a + 183 + 7) % STORE_N);
    return w;
  endfunction
endpackage

// File: rtl/mw_seq_store.sv
module mw_seq_store
  import mw_seq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] idx,
  output uword_t           word
);
  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = fill_word(i);
  end

  assign word = rom[idx];
endmodule

// File: rtl/mw_seq_nextsel.sv
module mw_seq_nextsel
  import mw_seq_pkg::*;
#(
  parameter int COND_W = 8,
  localparam int LO_W = $clog2(COND_W)
) (
  input  logic [CND_W-1:0]  csel,
  input  logic [COND_W-1:0] cond,
  input  logic [NA_W-1:0]   nxt0,
  input  logic [NA_W-1:0]   nxt1,
  input  logic [NA_W-1:0]   nxt2,
  input  logic [NA_W-1:0]   nxt3,
  output logic [NA_W-1:0]   next_addr
);
  logic [LO_W-1:0] lo_i, hi_i;
  logic            two_way;
  logic [1:0]      way;

  always_comb begin
    lo_i    = csel[LO_W-1:0];
    hi_i    = lo_i + 1'b1;
    two_way = csel[CND_W-1];
    way     = {(two_way ? 1'b0 : cond[hi_i]), cond[lo_i]};
    unique case (way)
      2'b00:   next_addr = nxt0;
      2'b01:   next_addr = nxt1;
      2'b10:   next_addr = nxt2;
      default: next_addr = nxt3;
    endcase
  end
endmodule

// File: rtl/mw_seq_decode.sv
module mw_seq_decode
  import mw_seq_pkg::*;
(
  input  logic [SEL_W-1:0] rsel,
  output logic [REG_N-1:0] reg_en
);
  for (genvar k = 0; k < REG_N; k++) begin : g_en
    assign reg_en[k] = (rsel == SEL_W'(k + 1));
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_seq_pkg::*;
#(
  parameter int COND_W = 8,
  parameter int DEPTH  = STORE_N,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond,
  output logic [REG_N-1:0]  reg_en,
  output logic [MUX_W-1:0]  src_sel
);
  logic [NA_W-1:0] uaddr;
  logic [NA_W-1:0] next_addr;
  uword_t          cur_word;
  logic            unused_hi;

  always_ff @(posedge clk) begin
    if (rst) uaddr <= '0;
    else     uaddr <= next_addr;
  end

  assign unused_hi = |uaddr[NA_W-1:IDX_W];

  mw_seq_store #(.DEPTH(DEPTH)) u_store (
    .idx  (uaddr[IDX_W-1:0]),
    .word (cur_word)
  );

  mw_seq_nextsel #(.COND_W(COND_W)) u_nextsel (
    .csel      (cur_word.csel),
    .cond      (cond),
    .nxt0      (cur_word.nxt0),
    .nxt1      (cur_word.nxt1),
    .nxt2      (cur_word.nxt2),
    .nxt3      (cur_word.nxt3),
    .next_addr (next_addr)
  );

  mw_seq_decode u_decode (
    .rsel   (cur_word.rsel),
    .reg_en (reg_en)
  );

  assign src_sel = cur_word.src;
endmodule

// File: rtl/mw_seq_checker.sv
module mw_seq_checker
  import mw_seq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REG_N-1:0] reg_en,
  input logic [MUX_W-1:0] src_sel,
  input logic [NA_W-1:0]  uaddr,
  input uword_t           word
);
  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_en)); // R3

  AST_IDLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    (word.rsel == '0) |-> (reg_en == '0)); // R3

  AST_RESET_ADDR: assert property (@(posedge clk)
    rst |=> (uaddr == '0)); // R8

  AST_NEXT_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (uaddr == $past(word.nxt0) || uaddr == $past(word.nxt1) ||
              uaddr == $past(word.nxt2) || uaddr == $past(word.nxt3))); // R7

  AST_TWO_WAY_ONLY: assert property (@(posedge clk) disable iff (rst)
    word.csel[CND_W-1] |=> (uaddr == $past(word.nxt0) ||
                            uaddr == $past(word.nxt1))); // R6

  AST_MOORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $stable(uaddr) |-> ($stable(reg_en) && $stable(src_sel))); // R9
endmodule

bind mw_seq mw_seq_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_en  (reg_en),
  .src_sel (src_sel),
  .uaddr   (uaddr),
  .word    (cur_word)
);

// File: tb/mw_seq_bench.sv
module mw_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam logic [7:0] VEC [NV] = '{
    8'h00, 8'h03, 8'h08, 8'hFF, 8'h01, 8'h02, 8'h55, 8'hAA,
    8'h0F, 8'hF0, 8'h81, 8'h42, 8'h24, 8'h18, 8'h7E, 8'hC3
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cond = '0;
  logic [14:0] reg_en;
  logic [3:0]  src_sel;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_seq u_mw_seq (
    .clk     (clk),
    .rst     (rst),
    .cond    (cond),
    .reg_en  (reg_en),
    .src_sel (src_sel)
  );

  function automatic int m_r(int a);    return (a % 16) ^ ((a / 16) % 16); endfunction
  function automatic int m_src(int a);  return (a / 16) % 16; endfunction
  function automatic int m_c(int a);    return (3 * a) % 16; endfunction
  function automatic int m_nx(int a, int k); return (13 * a + 61 * k + 7) % 256; endfunction

  function automatic int m_step(int a, logic [7:0] v);
    int c  = m_c(a);
    int lo = c % 8;
    int hb = (c >= 8) ? 0 : int'(v[(lo + 1) % 8]);
    return m_nx(a, hb * 2 + int'(v[lo]));
  endfunction

  function automatic logic [14:0] m_en(int a);
    int r = m_r(a);
    return (r == 0) ? 15'd0 : (15'd1 << (r - 1));
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (reg_en !== m_en(exp_addr)) begin
      errors++;
      $display("FAIL R3 %s addr %0d: reg_en actual %h expected %h", tag, exp_addr, reg_en, m_en(exp_addr));
    end
    checks++;
    if (src_sel !== 4'(m_src(exp_addr))) begin
      errors++;
      $display("FAIL R4 %s addr %0d: src_sel actual %h expected %h", tag, exp_addr, src_sel, m_src(exp_addr));
    end
  endtask

  // called at a falling edge
  task automatic step(input logic [7:0] v, input string tag);
    string t = (m_c(exp_addr) >= 8) ? {tag, " R6"} : {tag, " R5"};
    cond = v;
    @(posedge clk);
    exp_addr = m_step(exp_addr, v);
    @(negedge clk);
    compare(t);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_addr = 0;
  endtask

  initial begin
    logic [7:0] lf;
    do_reset();
    compare("R8 reset word");

    for (int i = 0; i < NV; i++) step(VEC[i], "R1 R2 R7 R10 table");

    lf = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf, "R2 R10 walk");
    end

    // reset mid-run, then a two-way word ignores its neighbour flag
    do_reset();
    compare("R8 mid-run reset");
    step(8'h03, "R7 index 11");
    step(8'h08, "R6 neighbour ignored");
    step(8'h00, "R7 index 00");

    // Moore: wiggle cond between edges, outputs must hold
    for (int j = 0; j < 4; j++) begin
      cond = 8'(j * 37 + 5);
      #1;
      compare("R9 cond wiggle");
    end
    @(posedge clk);
    exp_addr = m_step(exp_addr, cond);
    @(negedge clk);
    compare("R10 after wiggle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule